// File: doc/BRIEF.md
# Strobe-paced FIFO parallel port

This block is one 16-bit parallel port. A FIFO sits between a simple host register interface and an external peripheral. The peripheral paces every transfer with two wires. It drives an active-low request strobe into the block, and the block answers on an active-low acknowledge. One configuration bit sets the direction. In input mode the peripheral pushes words that the host later reads. In output mode the host loads words that the peripheral pulls one at a time.

The acknowledge follows one of two protocols. In the interlocked protocol it stays low until the peripheral releases its strobe. In the pulsed protocol it is a low pulse of fixed length. The host sees the current fill level. It also sees a flag that compares the level with a programmable threshold, and a sticky overflow bit for writes the FIFO could not accept. A one-cycle flush request empties the FIFO.

The strobe passes through a two-stage synchronizer. A falling edge therefore acts on the third rising clock edge after the strobe is first sampled low.

Top module: `hsfifo_port`

## Requirements
- R1: `fifo_level` is 0 after reset. It rises by one for each word accepted and falls by one for each word removed, and it never exceeds DEPTH (512 by default, 10-bit count).
- R2: `above_thresh` is 1 exactly when `fifo_level` is strictly greater than `cfg_thresh`, and 0 otherwise.
- R3: In output mode (`cfg_dir_out`=1) a host write to a full FIFO is discarded and sets `ovf_flag`. `ovf_flag` then stays 1 until a flush or a reset.
- R4: A one-cycle `flush_req` leaves `fifo_level` at 0 and clears `ovf_flag` on the next cycle.
- R5: In input mode a falling edge of `stb_in_n` stores `pin_data_in` into the FIFO and pulls `ack_out_n` low, three rising edges after the strobe is first low. If the FIFO is full, both the store and the acknowledge wait until the host has read a word.
- R6: In output mode a falling edge of `stb_in_n` moves the oldest word to `pin_data_out` and pulls `ack_out_n` low on the same edge. If the FIFO is empty, no acknowledge is given until the host writes a word.
- R7: With `cfg_pulsed`=0 (interlocked), `ack_out_n` stays low as long as `stb_in_n` stays low, and it returns high after the strobe returns high.
- R8: With `cfg_pulsed`=1, `ack_out_n` is low for exactly PULSE_CYC clock cycles (4 by default) per transfer.
- R9: Words leave the FIFO in the order they entered, in both directions.
- R10: `pin_oe` equals `cfg_dir_out`. Host writes have no effect in input mode, and host reads have no effect in output mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dir_out | input | 1 | 1 = output mode (host to peripheral), 0 = input mode |
| cfg_pulsed | input | 1 | 1 = pulsed acknowledge, 0 = interlocked |
| cfg_thresh | input | CNT_W | Level threshold for `above_thresh` |
| flush_req | input | 1 | One-cycle request that empties the FIFO |
| host_wr_en | input | 1 | Host write strobe (output mode) |
| host_wr_data | input | DATA_W | Host write word |
| host_rd_en | input | 1 | Host read strobe (input mode), pops the head word |
| host_rd_data | output | DATA_W | Head word of the FIFO |
| fifo_level | output | CNT_W | Words currently held |
| above_thresh | output | 1 | Level greater than threshold |
| ovf_flag | output | 1 | Sticky: a host write was dropped |
| stb_in_n | input | 1 | Active-low strobe from the peripheral |
| ack_out_n | output | 1 | Active-low acknowledge to the peripheral |
| pin_data_in | input | DATA_W | Parallel data from the peripheral |
| pin_data_out | output | DATA_W | Parallel data to the peripheral |
| pin_oe | output | 1 | Output enable for the data lines |

## Verification
A corrupted occupancy count shows up at once on `fifo_level` and on the threshold flag. It also shows up one host access later: a full FIFO stops accepting words early, or an empty one hands out stale data. A stuck handshake state shows up within a few cycles of the next strobe edge. It appears as a missing, early or over-long acknowledge, or as a word presented out of order on `pin_data_out`. The bench sweeps every threshold against every fill level of a small FIFO. It also walks both protocols through the empty and full stall cases.

// File: rtl/hsf_pkg.sv
package hsf_pkg;
  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_WAIT = 2'd1,
    HS_ACK  = 2'd2
  } hs_state_e;
endpackage

// File: rtl/hsf_sync.sv
// Two-stage synchronizer for the active-low strobe plus a falling-edge detect.
module hsf_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_n,
  output logic stb_lvl,
  output logic stb_fall
);
  logic [2:0] sh_q;
  logic [2:0] sh_d;

  always_comb sh_d = {sh_q[1:0], stb_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 3'b111;
    else        sh_q <= sh_d;
  end

  assign stb_lvl  = sh_q[1];
  assign stb_fall = sh_q[2] & ~sh_q[1];
endmodule

// File: rtl/hsf_fifo.sv
module hsf_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 512,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic              flush,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              do_push, do_pop;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & ~empty & ~flush;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = wp_q + 1'b1;
      if (do_pop)  rp_d = rp_q + 1'b1;
      if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
      else if (!do_push && do_pop) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  assign rdata = mem[rp_q];
  assign count = cnt_q;
endmodule

// File: rtl/hsf_hs_fsm.sv
// Acknowledge sequencer: waits for a strobe edge, then for FIFO readiness,
// then drives the acknowledge in the selected protocol.
module hsf_hs_fsm
  import hsf_pkg::*;
#(
  parameter int PULSE_CYC = 4,
  localparam int PW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulsed,
  input  logic stb_lvl,
  input  logic stb_fall,
  input  logic ready,
  output logic xfer,
  output logic ack_n
);
  hs_state_e   st_q, st_d;
  logic [PW-1:0] cnt_q, cnt_d;
  logic        ack_n_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    xfer  = 1'b0;
    unique case (st_q)
      HS_IDLE: begin
        if (stb_fall) begin
          if (ready) begin
            xfer  = 1'b1;
            st_d  = HS_ACK;
            cnt_d = '0;
          end else begin
            st_d = HS_WAIT;
          end
        end
      end
      HS_WAIT: begin
        if (ready) begin
          xfer  = 1'b1;
          st_d  = HS_ACK;
          cnt_d = '0;
        end
      end
      HS_ACK: begin
        if (pulsed) begin
          if (cnt_q == PW'(PULSE_CYC - 1)) st_d = HS_IDLE;
          else                             cnt_d = cnt_q + 1'b1;
        end else if (stb_lvl) begin
          st_d = HS_IDLE;
        end
      end
      default: st_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= HS_IDLE;
      cnt_q   <= '0;
      ack_n_q <= 1'b1;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      ack_n_q <= (st_d != HS_ACK);
    end
  end

  assign ack_n = ack_n_q;
endmodule

// File: rtl/hsfifo_port.sv
module hsfifo_port #(
  parameter int DATA_W    = 16,
  parameter int DEPTH     = 512,
  parameter int PULSE_CYC = 4,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_dir_out,
  input  logic              cfg_pulsed,
  input  logic [CNT_W-1:0]  cfg_thresh,
  input  logic              flush_req,
  input  logic              host_wr_en,
  input  logic [DATA_W-1:0] host_wr_data,
  input  logic              host_rd_en,
  output logic [DATA_W-1:0] host_rd_data,
  output logic [CNT_W-1:0]  fifo_level,
  output logic              above_thresh,
  output logic              ovf_flag,
  input  logic              stb_in_n,
  output logic              ack_out_n,
  input  logic [DATA_W-1:0] pin_data_in,
  output logic [DATA_W-1:0] pin_data_out,
  output logic              pin_oe
);
  logic              stb_lvl, stb_fall;
  logic              hs_ready, hs_xfer;
  logic              f_push, f_pop, f_full, f_empty;
  logic [DATA_W-1:0] f_wdata, f_rdata;
  logic [DATA_W-1:0] pout_q, pout_d;
  logic              ovf_q, ovf_d;

  hsf_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb_n    (stb_in_n),
    .stb_lvl  (stb_lvl),
    .stb_fall (stb_fall)
  );

  assign hs_ready = cfg_dir_out ? ~f_empty : ~f_full;

  hsf_hs_fsm #(.PULSE_CYC(PULSE_CYC)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .pulsed   (cfg_pulsed),
    .stb_lvl  (stb_lvl),
    .stb_fall (stb_fall),
    .ready    (hs_ready),
    .xfer     (hs_xfer),
    .ack_n    (ack_out_n)
  );

  assign f_push  = cfg_dir_out ? host_wr_en   : hs_xfer;
  assign f_pop   = cfg_dir_out ? hs_xfer      : host_rd_en;
  assign f_wdata = cfg_dir_out ? host_wr_data : pin_data_in;

  hsf_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (f_push),
    .pop   (f_pop),
    .flush (flush_req),
    .wdata (f_wdata),
    .rdata (f_rdata),
    .count (fifo_level),
    .full  (f_full),
    .empty (f_empty)
  );

  always_comb begin
    pout_d = pout_q;
    if (cfg_dir_out && hs_xfer) pout_d = f_rdata;
    ovf_d = ovf_q;
    if (flush_req)                                 ovf_d = 1'b0;
    else if (cfg_dir_out && host_wr_en && f_full)  ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pout_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      pout_q <= pout_d;
      ovf_q  <= ovf_d;
    end
  end

  assign host_rd_data = f_rdata;
  assign above_thresh = (fifo_level > cfg_thresh);
  assign ovf_flag     = ovf_q;
  assign pin_data_out = pout_q;
  assign pin_oe       = cfg_dir_out;
endmodule

// File: rtl/hsf_checker.sv
module hsf_checker #(
  parameter int DEPTH = 512,
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_dir_out,
  input logic             cfg_pulsed,
  input logic             flush_req,
  input logic             host_rd_en,
  input logic             stb_in_n,
  input logic [CNT_W-1:0] fifo_level,
  input logic             above_thresh,
  input logic             ovf_flag,
  input logic             ack_out_n
);
  a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= CNT_W'(DEPTH));

  a_r1_level_step: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_req |=> (fifo_level == $past(fifo_level)) ||
                   (fifo_level == $past(fifo_level) + 1'b1) ||
                   (fifo_level + 1'b1 == $past(fifo_level)));

  a_r2_flag_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    above_thresh |-> fifo_level != '0);

  a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !flush_req |=> ovf_flag);

  a_r4_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> (fifo_level == '0) && !ovf_flag);

  a_r5_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_dir_out && fifo_level == CNT_W'(DEPTH) && !flush_req && !host_rd_en
      |=> fifo_level == CNT_W'(DEPTH));

  a_r6_ack_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_dir_out && $fell(ack_out_n) |-> $past(fifo_level) != '0);

  a_r7_interlock_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_pulsed && !ack_out_n && !$past(stb_in_n) |=> !ack_out_n);

  a_r8_pulse_min: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_pulsed && $fell(ack_out_n) |=> !ack_out_n);
endmodule

bind hsfifo_port hsf_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_dir_out  (cfg_dir_out),
  .cfg_pulsed   (cfg_pulsed),
  .flush_req    (flush_req),
  .host_rd_en   (host_rd_en),
  .stb_in_n     (stb_in_n),
  .fifo_level   (fifo_level),
  .above_thresh (above_thresh),
  .ovf_flag     (ovf_flag),
  .ack_out_n    (ack_out_n)
);

// File: tb/tb_hsfifo_port.sv
module tb_hsfifo_port;
  localparam int DW    = 16;
  localparam int DEP   = 8;
  localparam int PC    = 4;
  localparam int CW    = $clog2(DEP + 1);

  logic clk = 1'b0;
  logic rst_n, cfg_dir_out, cfg_pulsed, flush_req, host_wr_en, host_rd_en, stb_in_n;
  logic [CW-1:0] cfg_thresh;
  logic [DW-1:0] host_wr_data, pin_data_in;
  logic [DW-1:0] host_rd_data, pin_data_out;
  logic [CW-1:0] fifo_level;
  logic above_thresh, ovf_flag, ack_out_n, pin_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hsfifo_port #(.DATA_W(DW), .DEPTH(DEP), .PULSE_CYC(PC)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_dir_out(cfg_dir_out), .cfg_pulsed(cfg_pulsed),
    .cfg_thresh(cfg_thresh), .flush_req(flush_req), .host_wr_en(host_wr_en),
    .host_wr_data(host_wr_data), .host_rd_en(host_rd_en), .host_rd_data(host_rd_data),
    .fifo_level(fifo_level), .above_thresh(above_thresh), .ovf_flag(ovf_flag),
    .stb_in_n(stb_in_n), .ack_out_n(ack_out_n), .pin_data_in(pin_data_in),
    .pin_data_out(pin_data_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic host_write(input logic [DW-1:0] d);
    host_wr_en = 1'b1; host_wr_data = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic host_read();
    host_rd_en = 1'b1;
    @(negedge clk);
    host_rd_en = 1'b0;
  endtask

  // wait until ack_out_n equals val, up to 40 cycles; returns cycles waited
  task automatic wait_ack(input logic val, output int n);
    n = 0;
    while (ack_out_n !== val && n < 40) begin
      @(negedge clk); n++;
    end
  endtask

  function automatic logic [DW-1:0] wv(input int i);
    return DW'(16'hA100 + i * 16'h0111);
  endfunction

  function automatic logic [DW-1:0] iv(input int i);
    return DW'(16'h3C00 ^ (i * 16'h0909));
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; cfg_dir_out = 1'b1; cfg_pulsed = 1'b0; flush_req = 1'b0;
    host_wr_en = 1'b0; host_rd_en = 1'b0; stb_in_n = 1'b1;
    cfg_thresh = '0; host_wr_data = '0; pin_data_in = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // reset state
    chk("R1 reset level", fifo_level, 0);
    chk("R3 reset ovf", ovf_flag, 0);
    chk("R7 reset ack", ack_out_n, 1);
    chk("R10 oe output", pin_oe, 1);

    // R1/R2: fill in output mode, sweep every threshold at every level
    for (int lv = 0; lv <= DEP; lv++) begin
      chk("R1 level", fifo_level, lv);
      for (int t = 0; t <= DEP; t++) begin
        cfg_thresh = CW'(t);
        #1;
        chk("R2 thresh", above_thresh, (lv > t) ? 1 : 0);
      end
      if (lv < DEP) host_write(wv(lv));
    end
    cfg_thresh = '0;

    // R3: write when full
    chk("R3 no ovf before", ovf_flag, 0);
    host_write(16'hDEAD);
    chk("R3 full write dropped", fifo_level, DEP);
    chk("R3 ovf set", ovf_flag, 1);
    cyc(3);
    chk("R3 ovf sticky", ovf_flag, 1);
    // R10: host read ignored in output mode
    host_read();
    chk("R10 read ignored out", fifo_level, DEP);

    // R6/R7: interlocked output transfer with exact latency
    stb_in_n = 1'b0;
    cyc(2);
    chk("R6 ack not yet", ack_out_n, 1);
    cyc(1);
    chk("R6 ack latency", ack_out_n, 0);
    chk("R9 first word out", pin_data_out, wv(0));
    chk("R6 level pop", fifo_level, DEP - 1);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (ack_out_n) n++;
    end
    chk("R7 ack held while strobe low", n, 0);
    stb_in_n = 1'b1;
    wait_ack(1'b1, n);
    chk("R7 ack released", ack_out_n, 1);
    chk("R7 release delay", n, 3);
    cyc(2);

    // R8: pulsed output, drain remaining words
    cfg_pulsed = 1'b1;
    for (int k = 1; k < DEP; k++) begin
      stb_in_n = 1'b0;
      wait_ack(1'b0, n);
      chk("R8 ack seen", ack_out_n, 0);
      chk("R9 order out", pin_data_out, wv(k));
      n = 0;
      while (!ack_out_n && n < 40) begin
        @(negedge clk); n++;
      end
      chk("R8 pulse width", n, PC);
      stb_in_n = 1'b1;
      cyc(3);
    end
    chk("R1 drained", fifo_level, 0);

    // R6: strobe on empty FIFO is held off until the host writes
    stb_in_n = 1'b0;
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!ack_out_n) n++;
    end
    chk("R6 no ack when empty", n, 0);
    host_write(16'h5A5A);
    wait_ack(1'b0, n);
    chk("R6 ack after write", ack_out_n, 0);
    chk("R6 late word out", pin_data_out, 16'h5A5A);
    chk("R6 level after late pop", fifo_level, 0);
    stb_in_n = 1'b1;
    cyc(8);

    // R4: flush clears level and overflow
    for (int i = 0; i < 3; i++) host_write(DW'(i));
    chk("R1 level three", fifo_level, 3);
    chk("R3 ovf still set", ovf_flag, 1);
    flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;
    chk("R4 flush level", fifo_level, 0);
    chk("R4 flush ovf", ovf_flag, 0);

    // R10: input mode, host write ignored
    cfg_dir_out = 1'b0;
    #1;
    chk("R10 oe input", pin_oe, 0);
    host_write(16'h1234);
    chk("R10 write ignored in", fifo_level, 0);
    host_read();
    chk("R10 empty read no effect", fifo_level, 0);

    // R5: capture words with pulsed acknowledge
    for (int k = 0; k < DEP; k++) begin
      pin_data_in = iv(k);
      stb_in_n = 1'b0;
      if (k == 0) begin
        cyc(2);
        chk("R5 ack not yet", ack_out_n, 1);
        cyc(1);
        chk("R5 ack latency", ack_out_n, 0);
      end else begin
        wait_ack(1'b0, n);
        chk("R5 ack", ack_out_n, 0);
      end
      chk("R5 level", fifo_level, k + 1);
      wait_ack(1'b1, n);
      stb_in_n = 1'b1;
      cyc(3);
    end
    // full: next strobe stalls
    pin_data_in = 16'hBEEF;
    stb_in_n = 1'b0;
    n = 0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (!ack_out_n) n++;
    end
    chk("R5 stall when full", n, 0);
    chk("R5 full level", fifo_level, DEP);
    chk("R9 head in", host_rd_data, iv(0));
    host_read();
    wait_ack(1'b0, n);
    chk("R5 ack after space", ack_out_n, 0);
    wait_ack(1'b1, n);
    stb_in_n = 1'b1;
    cyc(3);
    chk("R5 refilled", fifo_level, DEP);
    for (int k = 1; k <= DEP; k++) begin
      chk("R9 order in", host_rd_data, (k < DEP) ? iv(k) : 16'hBEEF);
      host_read();
    end
    chk("R1 empty after reads", fifo_level, 0);

    // R7: interlocked input capture
    cfg_pulsed = 1'b0;
    pin_data_in = 16'h0F0F;
    stb_in_n = 1'b0;
    wait_ack(1'b0, n);
    cyc(6);
    chk("R7 input ack held", ack_out_n, 0);
    stb_in_n = 1'b1;
    wait_ack(1'b1, n);
    chk("R7 input ack released", ack_out_n, 1);
    chk("R5 interlocked word", host_rd_data, 16'h0F0F);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule